// File: doc/BRIEF.md
# Post-Modify Operand Address Generator

This block turns the three 7-bit operand specifiers of a floating-point multiply-add style instruction (two sources, X and Y, and one destination, Z) into effective memory addresses and pointer write-backs. Each specifier either names an accumulator or names a general pointer register together with a post-modify rule. The memory access always uses the pointer's value before modification. The modified value is presented on a write port of its own for each operand, so that the surrounding register file commits it on the clock edge that ends the decode cycle.

The block reads the current register file from a flat input vector. It reports whether each source is a memory or accumulator operand. It raises an illegal-operand flag for encodings that must not be used. It also raises a one-cycle hazard pulse when the current instruction reads a pointer that the previous instruction's destination operand had just modified. A companion bit tells a decrementing update apart from an incrementing one.

Top module: `postmod_agu`

## Requirements
- R1: An operand splits into a pointer field in bits [6:3] and a mode field in bits [2:0]. A pointer field of 0 on X or Y is an accumulator operand: IsMem is 0, Acc carries bits [1:0], the address is 0 and no write is enabled.
- R2: On X or Y, a pointer field of 0 with bit 2 set is illegal (illegal = 1).
- R3: A pointer field of 15 on any operand is illegal.
- R4: For a memory operand, the address output equals the selected pointer register's value before any modification.
- R5: Mode 0 enables no write. Mode 6 writes pointer minus step and mode 7 writes pointer plus step, where the step is srcStep for X and Y and dstStep for Z. WrIdx is the pointer field.
- R6: Modes 1 to 5 write the pointer plus index register r(NREG-6+mode), which is r15 to r19 by default.
- R7: On Z, pointer 0 with mode 7 (zOp = 7'h07) means no store: zStore = 0, no write, not illegal. Pointer 0 with any other mode is illegal. A legal memory Z sets zStore.
- R8: While any operand is illegal, all three write enables are 0.
- R9: hazard is 1 for one cycle when the current valid instruction's X or Y operand reads, as pointer or as index, the register written by the Z update of the instruction in the immediately preceding cycle. hazardDec is 1 if that update was mode 6 and 0 otherwise.
- R10: When X and Y both modify the same pointer register, only the Y write is enabled.
- R11: With instValid low there are no writes, no store and no hazard, and the next cycle sees no hazard history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | An instruction is decoded this cycle |
| xOp | input | 7 | X source operand specifier |
| yOp | input | 7 | Y source operand specifier |
| zOp | input | 7 | Z destination operand specifier |
| srcStep | input | SW (3) | Access size in bytes for X and Y post-modify |
| dstStep | input | SW (3) | Access size in bytes for Z post-modify |
| regFlat | input | NREG*DW (640) | Register file contents, register i at bits [i*DW +: DW] |
| xIsMem | output | 1 | X is a memory operand |
| xAcc | output | 2 | X accumulator index |
| xAddr | output | DW | X effective address |
| xWrEn | output | 1 | X pointer write enable |
| xWrIdx | output | 4 | X pointer register number |
| xWrData | output | DW | X updated pointer value |
| yIsMem | output | 1 | Y is a memory operand |
| yAcc | output | 2 | Y accumulator index |
| yAddr | output | DW | Y effective address |
| yWrEn | output | 1 | Y pointer write enable |
| yWrIdx | output | 4 | Y pointer register number |
| yWrData | output | DW | Y updated pointer value |
| zStore | output | 1 | Z result is stored to memory |
| zAddr | output | DW | Z effective address |
| zWrEn | output | 1 | Z pointer write enable |
| zWrIdx | output | 4 | Z pointer register number |
| zWrData | output | DW | Z updated pointer value |
| illegal | output | 1 | Illegal operand in this instruction |
| hazard | output | 1 | Read of a pointer modified by the previous instruction |
| hazardDec | output | 1 | The modification behind the hazard was a decrement |

## Verification
The X operand is swept over accumulator codes, the reserved accumulator code, every post-modify mode and pointer 15. This separates the no-modify, decrement, increment and indexed adders, and tells the pre-modify address apart from the written value. Directed patterns give the destination a different step size from the sources, so that a swapped step shows up. They also put X and Y on one pointer to expose the priority rule, and pair a legal update with an illegal neighbour to show that writes are suppressed. Hazard patterns cover back-to-back increment and decrement updates, the cycle after the pulse, and an idle cycle in between, which tell the pulse, its direction bit and its one-cycle history apart.

// File: rtl/postmod_agu_pkg.sv
package postmod_agu_pkg;

  localparam int OP_W   = 7;
  localparam int PTR_W  = 4;
  localparam int MODE_W = 3;
  localparam logic [PTR_W-1:0]  PTR_NONE    = '0;
  localparam logic [PTR_W-1:0]  PTR_BAD     = '1;
  localparam logic [MODE_W-1:0] MODE_DEC    = 3'd6;
  localparam logic [MODE_W-1:0] MODE_INC    = 3'd7;
  localparam logic [OP_W-1:0]   OP_NOSTORE  = 7'h07;

  typedef enum logic [1:0] {
    MOD_NONE = 2'd0,
    MOD_DEC  = 2'd1,
    MOD_INC  = 2'd2,
    MOD_IDX  = 2'd3
  } modKind_e;

  // Decoded view of one operand, used inside the control
  typedef struct packed {
    logic              isMem;
    logic [PTR_W-1:0]  ptr;
    logic [MODE_W-1:0] mode;
    modKind_e          kind;
    logic              bad;
  } opDec_t;

  // Strobes the control hands to one datapath lane
  typedef struct packed {
    logic              isMem;
    logic [PTR_W-1:0]  ptr;
    logic [MODE_W-1:0] mode;
    modKind_e          kind;
    logic              wrEn;
  } opStrobe_t;

  function automatic modKind_e kindOf(input logic [MODE_W-1:0] mode);
    case (mode)
      3'd0:     kindOf = MOD_NONE;
      MODE_DEC: kindOf = MOD_DEC;
      MODE_INC: kindOf = MOD_INC;
      default:  kindOf = MOD_IDX;
    endcase
  endfunction

  function automatic opDec_t decodeOp(input logic [OP_W-1:0] op, input logic isDst);
    opDec_t d;
    d.ptr   = op[OP_W-1:MODE_W];
    d.mode  = op[MODE_W-1:0];
    d.isMem = (d.ptr != PTR_NONE);
    d.kind  = d.isMem ? kindOf(d.mode) : MOD_NONE;
    if (d.ptr == PTR_BAD)
      d.bad = 1'b1;
    else if (!d.isMem)
      d.bad = isDst ? (d.mode != MODE_INC) : d.mode[2];
    else
      d.bad = 1'b0;
    return d;
  endfunction

endpackage

// File: rtl/postmod_agu_ctrl.sv
module postmod_agu_ctrl
  import postmod_agu_pkg::*;
#(
  parameter int NREG = 20
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            instValid,
  input  logic [OP_W-1:0] xOp,
  input  logic [OP_W-1:0] yOp,
  input  logic [OP_W-1:0] zOp,
  output opStrobe_t       xStb,
  output opStrobe_t       yStb,
  output opStrobe_t       zStb,
  output logic [1:0]      xAcc,
  output logic [1:0]      yAcc,
  output logic            zStore,
  output logic            illegal,
  output logic            hazard,
  output logic            hazardDec
);

  localparam int IDX_BASE = NREG - 6;

  opDec_t xDec, yDec, zDec;
  logic   xMod, yMod, zMod, sameXY;
  logic   prevValid, prevDec;
  logic [PTR_W-1:0] prevReg;

  function automatic logic readsReg(input opDec_t d, input logic [PTR_W-1:0] r);
    int idxNum;
    idxNum = IDX_BASE + int'(d.mode);
    return d.isMem && ((d.ptr == r) || (d.kind == MOD_IDX && idxNum == int'(r)));
  endfunction

  always_comb begin
    xDec = decodeOp(xOp, 1'b0);
    yDec = decodeOp(yOp, 1'b0);
    zDec = decodeOp(zOp, 1'b1);
  end

  assign illegal = instValid && (xDec.bad || yDec.bad || zDec.bad);

  assign xMod   = instValid && !illegal && xDec.isMem && (xDec.kind != MOD_NONE);
  assign yMod   = instValid && !illegal && yDec.isMem && (yDec.kind != MOD_NONE);
  assign zMod   = instValid && !illegal && zDec.isMem && (zDec.kind != MOD_NONE);
  assign sameXY = xMod && yMod && (xDec.ptr == yDec.ptr);

  always_comb begin
    xStb = '{isMem: xDec.isMem, ptr: xDec.ptr, mode: xDec.mode, kind: xDec.kind,
             wrEn: xMod && !sameXY};
    yStb = '{isMem: yDec.isMem, ptr: yDec.ptr, mode: yDec.mode, kind: yDec.kind,
             wrEn: yMod};
    zStb = '{isMem: zDec.isMem, ptr: zDec.ptr, mode: zDec.mode, kind: zDec.kind,
             wrEn: zMod};
  end

  assign xAcc   = xDec.isMem ? 2'd0 : xOp[1:0];
  assign yAcc   = yDec.isMem ? 2'd0 : yOp[1:0];
  assign zStore = instValid && !illegal && zDec.isMem;

  // One-cycle history of the destination pointer update
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevValid <= 1'b0;
      prevReg   <= '0;
      prevDec   <= 1'b0;
    end else begin
      prevValid <= zMod;
      prevReg   <= zDec.ptr;
      prevDec   <= (zDec.kind == MOD_DEC);
    end
  end

  assign hazard    = instValid && prevValid &&
                     (readsReg(xDec, prevReg) || readsReg(yDec, prevReg));
  assign hazardDec = hazard && prevDec;

  AST_PTR15_ILLEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && (xOp[6:3] == 4'hF || yOp[6:3] == 4'hF || zOp[6:3] == 4'hF)) |-> illegal); // R3
  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> !(xStb.wrEn || yStb.wrEn || zStb.wrEn)); // R8
  AST_NOSTORE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && zOp == OP_NOSTORE) |-> (!zStore && !zStb.wrEn)); // R7
  AST_XY_DISTINCT: assert property (@(posedge clk) disable iff (!rstN)
    (xStb.wrEn && yStb.wrEn) |-> (xStb.ptr != yStb.ptr)); // R10
  AST_HAZARD_NEEDS_UPDATE: assert property (@(posedge clk) disable iff (!rstN)
    hazard |-> $past(zStb.wrEn)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |-> !(hazard || zStore || xStb.wrEn || yStb.wrEn || zStb.wrEn)); // R11

endmodule

// File: rtl/postmod_agu_dp.sv
module postmod_agu_dp
  import postmod_agu_pkg::*;
#(
  parameter int NREG = 20,
  parameter int DW   = 32,
  parameter int SW   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NREG*DW-1:0] regFlat,
  input  opStrobe_t          stb,
  input  logic [SW-1:0]      step,
  output logic [DW-1:0]      addr,
  output logic               wrEn,
  output logic [PTR_W-1:0]   wrIdx,
  output logic [DW-1:0]      wrData
);

  localparam int IDX_BASE = NREG - 6;

  logic [DW-1:0] ptrVal, idxVal, stepExt;
  int            idxNum;

  assign ptrVal  = regFlat[int'(stb.ptr)*DW +: DW];
  assign idxNum  = (stb.kind == MOD_IDX) ? IDX_BASE + int'(stb.mode) : 0;
  assign idxVal  = regFlat[idxNum*DW +: DW];
  assign stepExt = DW'(step);

  assign addr  = stb.isMem ? ptrVal : '0;
  assign wrEn  = stb.wrEn;
  assign wrIdx = stb.ptr;

  always_comb begin
    case (stb.kind)
      MOD_DEC: wrData = ptrVal - stepExt;
      MOD_INC: wrData = ptrVal + stepExt;
      MOD_IDX: wrData = ptrVal + idxVal;
      default: wrData = ptrVal;
    endcase
  end

  AST_NOMOD_NOWRITE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.kind == MOD_NONE) |-> !wrEn); // R5
  AST_WRITE_ONLY_MEM: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> stb.isMem); // R1

endmodule

// File: rtl/postmod_agu.sv
module postmod_agu
  import postmod_agu_pkg::*;
#(
  parameter int NREG = 20,
  parameter int DW   = 32,
  parameter int SW   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instValid,
  input  logic [6:0]         xOp,
  input  logic [6:0]         yOp,
  input  logic [6:0]         zOp,
  input  logic [SW-1:0]      srcStep,
  input  logic [SW-1:0]      dstStep,
  input  logic [NREG*DW-1:0] regFlat,
  output logic               xIsMem,
  output logic [1:0]         xAcc,
  output logic [DW-1:0]      xAddr,
  output logic               xWrEn,
  output logic [3:0]         xWrIdx,
  output logic [DW-1:0]      xWrData,
  output logic               yIsMem,
  output logic [1:0]         yAcc,
  output logic [DW-1:0]      yAddr,
  output logic               yWrEn,
  output logic [3:0]         yWrIdx,
  output logic [DW-1:0]      yWrData,
  output logic               zStore,
  output logic [DW-1:0]      zAddr,
  output logic               zWrEn,
  output logic [3:0]         zWrIdx,
  output logic [DW-1:0]      zWrData,
  output logic               illegal,
  output logic               hazard,
  output logic               hazardDec
);

  localparam int NLANE = 3;

  opStrobe_t                  xStb, yStb, zStb;
  opStrobe_t [NLANE-1:0]      laneStb;
  logic [NLANE-1:0][SW-1:0]   laneStep;
  logic [NLANE-1:0][DW-1:0]   laneAddr, laneData;
  logic [NLANE-1:0]           laneWr;
  logic [NLANE-1:0][PTR_W-1:0] laneIdx;

  postmod_agu_ctrl #(.NREG(NREG)) u_ctrl (
    .clk(clk), .rstN(rstN), .instValid(instValid),
    .xOp(xOp), .yOp(yOp), .zOp(zOp),
    .xStb(xStb), .yStb(yStb), .zStb(zStb),
    .xAcc(xAcc), .yAcc(yAcc), .zStore(zStore),
    .illegal(illegal), .hazard(hazard), .hazardDec(hazardDec)
  );

  assign laneStb  = {zStb, yStb, xStb};
  assign laneStep = {dstStep, srcStep, srcStep};

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    postmod_agu_dp #(.NREG(NREG), .DW(DW), .SW(SW)) u_dp (
      .clk(clk), .rstN(rstN), .regFlat(regFlat),
      .stb(laneStb[g]), .step(laneStep[g]),
      .addr(laneAddr[g]), .wrEn(laneWr[g]),
      .wrIdx(laneIdx[g]), .wrData(laneData[g])
    );
  end

  assign xIsMem  = xStb.isMem;
  assign yIsMem  = yStb.isMem;
  assign xAddr   = laneAddr[0];
  assign yAddr   = laneAddr[1];
  assign zAddr   = laneAddr[2];
  assign xWrEn   = laneWr[0];
  assign yWrEn   = laneWr[1];
  assign zWrEn   = laneWr[2];
  assign xWrIdx  = laneIdx[0];
  assign yWrIdx  = laneIdx[1];
  assign zWrIdx  = laneIdx[2];
  assign xWrData = laneData[0];
  assign yWrData = laneData[1];
  assign zWrData = laneData[2];

endmodule

// File: tb/test_postmod_agu.sv
`timescale 1ns/1ps
module test_postmod_agu;

  localparam int NREG = 20;
  localparam int DW   = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instValid = 1'b0;
  logic [6:0] xOp = 7'h00, yOp = 7'h00, zOp = 7'h07;
  logic [2:0] srcStep = 3'd4, dstStep = 3'd4;
  logic [NREG*DW-1:0] regFlat;
  logic xIsMem, yIsMem, xWrEn, yWrEn, zWrEn, zStore, illegal, hazard, hazardDec;
  logic [1:0] xAcc, yAcc;
  logic [3:0] xWrIdx, yWrIdx, zWrIdx;
  logic [DW-1:0] xAddr, yAddr, zAddr, xWrData, yWrData, zWrData;

  int tests = 0, fails = 0, cyc = 0;

  always #2 clk = ~clk;

  postmod_agu i_postmod_agu (
    .clk(clk), .rstN(rstN), .instValid(instValid),
    .xOp(xOp), .yOp(yOp), .zOp(zOp), .srcStep(srcStep), .dstStep(dstStep),
    .regFlat(regFlat),
    .xIsMem(xIsMem), .xAcc(xAcc), .xAddr(xAddr), .xWrEn(xWrEn), .xWrIdx(xWrIdx), .xWrData(xWrData),
    .yIsMem(yIsMem), .yAcc(yAcc), .yAddr(yAddr), .yWrEn(yWrEn), .yWrIdx(yWrIdx), .yWrData(yWrData),
    .zStore(zStore), .zAddr(zAddr), .zWrEn(zWrEn), .zWrIdx(zWrIdx), .zWrData(zWrData),
    .illegal(illegal), .hazard(hazard), .hazardDec(hazardDec)
  );

  // Pointers r1..r14 hold 0x100*i; index registers r15..r19 hold 8*(i-14)
  initial begin
    for (int i = 0; i < NREG; i++)
      regFlat[i*DW +: DW] = (i >= 15) ? DW'((i - 14) * 8) : DW'(i * 256);
  end

  typedef struct packed {
    logic [6:0]  op;
    logic        isMem;
    logic [1:0]  acc;
    logic [31:0] addr;
    logic        wr;
    logic [31:0] data;
    logic        ill;
  } vec_t;

  // X operand sweep, srcStep = 4
  localparam vec_t VEC [10] = '{
    '{7'h00, 1'b0, 2'd0, 32'h0,   1'b0, 32'h0,   1'b0},  // R1 a0
    '{7'h03, 1'b0, 2'd3, 32'h0,   1'b0, 32'h0,   1'b0},  // R1 a3
    '{7'h04, 1'b0, 2'd0, 32'h0,   1'b0, 32'h0,   1'b1},  // R2
    '{7'h10, 1'b1, 2'd0, 32'h200, 1'b0, 32'h0,   1'b0},  // R4 R5 mode 0
    '{7'h17, 1'b1, 2'd0, 32'h200, 1'b1, 32'h204, 1'b0},  // R5 inc
    '{7'h1E, 1'b1, 2'd0, 32'h300, 1'b1, 32'h2FC, 1'b0},  // R5 dec
    '{7'h29, 1'b1, 2'd0, 32'h500, 1'b1, 32'h508, 1'b0},  // R6 r15
    '{7'h2D, 1'b1, 2'd0, 32'h500, 1'b1, 32'h528, 1'b0},  // R6 r19
    '{7'h78, 1'b1, 2'd0, 32'h0,   1'b0, 32'h0,   1'b1},  // R3
    '{7'h73, 1'b1, 2'd0, 32'hE00, 1'b1, 32'hE18, 1'b0}   // R6 r17
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [6:0] x, input logic [6:0] y, input logic [6:0] z);
    @(negedge clk);
    instValid = v; xOp = x; yOp = y; zOp = z;
    #1;
  endtask

  initial begin
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    fails++;
    $display("FAIL watchdog: got %0d expected below 100000", cyc);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset hazard", 32'(hazard), 0);
    check("R11 reset writes", 32'({xWrEn, yWrEn, zWrEn, zStore}), 0);
    @(negedge clk);
    rstN = 1'b1;

    // Table walk on X, Y = a0, Z = no store
    foreach (VEC[k]) begin
      drive(1'b1, VEC[k].op, 7'h00, 7'h07);
      check($sformatf("R1 isMem v%0d", k), 32'(xIsMem), 32'(VEC[k].isMem));
      check($sformatf("R2 R3 illegal v%0d", k), 32'(illegal), 32'(VEC[k].ill));
      check($sformatf("R5 R6 wrEn v%0d", k), 32'(xWrEn), 32'(VEC[k].wr));
      if (!VEC[k].isMem)
        check($sformatf("R1 acc v%0d", k), 32'(xAcc), 32'(VEC[k].acc));
      if (!VEC[k].ill && VEC[k].isMem)
        check($sformatf("R4 addr v%0d", k), xAddr, VEC[k].addr);
      if (VEC[k].wr) begin
        check($sformatf("R5 R6 data v%0d", k), xWrData, VEC[k].data);
        check($sformatf("R5 idx v%0d", k), 32'(xWrIdx), 32'(VEC[k].op[6:3]));
      end
    end

    // Z step differs from source step
    srcStep = 3'd4; dstStep = 3'd2;
    drive(1'b1, 7'h00, 7'h00, 7'h27);
    check("R7 zStore", 32'(zStore), 1);
    check("R4 zAddr", zAddr, 32'h400);
    check("R5 zWrData step", zWrData, 32'h402);
    check("R5 zWrIdx", 32'(zWrIdx), 4);
    drive(1'b1, 7'h00, 7'h00, 7'h07);
    check("R7 nostore zStore", 32'(zStore), 0);
    check("R7 nostore illegal", 32'(illegal), 0);
    drive(1'b1, 7'h00, 7'h00, 7'h01);
    check("R7 Z acc illegal", 32'(illegal), 1);
    drive(1'b1, 7'h00, 7'h00, 7'h7F);
    check("R3 Z ptr15 illegal", 32'(illegal), 1);

    // Illegal neighbour suppresses a legal update
    drive(1'b1, 7'h17, 7'h05, 7'h27);
    check("R8 illegal", 32'(illegal), 1);
    check("R8 writes", 32'({xWrEn, yWrEn, zWrEn}), 0);

    // X and Y on one pointer
    drive(1'b1, 7'h17, 7'h16, 7'h07);
    check("R10 xWrEn", 32'(xWrEn), 0);
    check("R10 yWrEn", 32'(yWrEn), 1);
    check("R10 yWrData", yWrData, 32'h1FC);

    // Hazard after increment
    drive(1'b1, 7'h00, 7'h00, 7'h1F);
    check("R9 no hazard yet", 32'(hazard), 0);
    drive(1'b1, 7'h18, 7'h00, 7'h07);
    check("R9 hazard", 32'(hazard), 1);
    check("R9 hazardDec inc", 32'(hazardDec), 0);
    drive(1'b1, 7'h18, 7'h00, 7'h07);
    check("R9 pulse ends", 32'(hazard), 0);

    // Hazard after decrement, seen by Y
    drive(1'b1, 7'h00, 7'h00, 7'h26);
    drive(1'b1, 7'h00, 7'h27, 7'h07);
    check("R9 hazard Y", 32'(hazard), 1);
    check("R9 hazardDec dec", 32'(hazardDec), 1);

    // Idle cycle clears history
    drive(1'b1, 7'h00, 7'h00, 7'h1F);
    drive(1'b0, 7'h17, 7'h00, 7'h27);
    check("R11 idle writes", 32'({xWrEn, yWrEn, zWrEn, zStore}), 0);
    check("R11 idle hazard", 32'(hazard), 0);
    drive(1'b1, 7'h18, 7'h00, 7'h07);
    check("R11 history cleared", 32'(hazard), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule